// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

The block connects two processor cores through two one-way word queues. Each core pushes words into its own outbound queue, and that queue is the inbound queue of the other core. Each core pops words only from its own inbound queue. Each core has a push port, a pop port with registered read data, a status word, and a status write strobe.

The status word shows whether the core may push (its outbound queue has room) and whether a pop will return data (its inbound queue holds a word). It also holds two sticky error flags. One records a push that was refused because the outbound queue was full. The other records a pop that was refused because the inbound queue was empty. A refused access never changes the stored words or the queue pointers. Software clears an error flag by writing a one to that flag's bit of the status word.

Top module: `mbox_fifo_pair`

## Requirements
- R1: Words are 32 bits wide. A word pushed by core k is popped by the other core in push order, and it appears on that core's pop_data_o one cycle after the accepted pop.
- R2: Each queue holds 8 words. Ready (status bit 1) stays 1 after the 7th push into an empty queue. It goes to 0 one cycle after the 8th push.
- R3: A push while the outbound queue is full is dropped. It sets the overflow flag (status bit 2) from the next cycle on, and the queued words are left unchanged.
- R4: A pop while the inbound queue is empty is dropped. It sets the underflow flag (status bit 3) from the next cycle on and returns zero on pop_data_o. The read pointer does not move.
- R5: A status write with a 1 in bit 2 or bit 3 clears that flag, and a 0 leaves it as it was. The flags are sticky until cleared. A new error in the same cycle as a clear leaves the flag set.
- R6: Status bit 1 equals 1 whenever the core's outbound queue is not full.
- R7: Status bit 0 equals 1 whenever the core's inbound queue is not empty. It becomes 1 one cycle after a push by the other core into an empty queue.
- R8: Status bits 31 to 4 always read as zero.
- R9: A push and a pop in the same cycle on a queue that is neither full nor empty leave its occupancy unchanged.
- R10: During and after reset both queues are empty. Each status word reads 0x00000002, and both pop_data_o buses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 2 | Push strobe per core, into that core's outbound queue |
| push_data_i | input | 2x32 | Push word per core |
| pop_i | input | 2 | Pop strobe per core, from that core's inbound queue |
| pop_data_o | output | 2x32 | Registered pop word per core, zero when no word was taken |
| stat_wr_i | input | 2 | Status write strobe per core |
| stat_wdata_i | input | 2x32 | Status write data: bit 2 clears overflow, bit 3 clears underflow |
| stat_o | output | 2x32 | Status per core: bit 0 valid, bit 1 ready, bit 2 overflow, bit 3 underflow |

## Verification
Every result is due one clock edge after the request that causes it. The edge that takes a pop also loads pop_data_o. The edge that takes a push or pop also updates the occupancy that ready and valid read. The edge that sees a refused access or a clear also updates the flags. The bench changes inputs on the falling edge and samples outputs on the next falling edge, so exactly one rising edge separates stimulus from check. The check after the 7th and 8th push, the same-cycle push and pop, and the clear that meets a new overflow all sit on that single-edge boundary.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NCORE     = 2;
  localparam int unsigned ST_VALID  = 0;
  localparam int unsigned ST_READY  = 1;
  localparam int unsigned ST_OVF    = 2;
  localparam int unsigned ST_UNF    = 3;
  localparam int unsigned ST_USED_W = 4;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mbox_core_stat.sv
module mbox_core_stat
  import mbox_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          tx_full_i,
  input  logic          rx_empty_i,
  input  logic [DW-1:0] rx_head_i,
  input  logic          stat_wr_i,
  input  logic [DW-1:0] stat_wdata_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] rd_data_o
);
  logic ovf_q, unf_q;
  logic ovf_set, unf_set, ovf_clr, unf_clr;

  assign ovf_set = push_i & tx_full_i;
  assign unf_set = pop_i & rx_empty_i;
  assign ovf_clr = stat_wr_i & stat_wdata_i[ST_OVF];
  assign unf_clr = stat_wr_i & stat_wdata_i[ST_UNF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      // a fresh error outranks a clear in the same cycle
      ovf_q     <= ovf_set | (ovf_q & ~ovf_clr);
      unf_q     <= unf_set | (unf_q & ~unf_clr);
      rd_data_o <= (pop_i & ~rx_empty_i) ? rx_head_i : '0;
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[ST_VALID] = ~rx_empty_i;
    stat_o[ST_READY] = ~tx_full_i;
    stat_o[ST_OVF]   = ovf_q;
    stat_o[ST_UNF]   = unf_q;
  end
endmodule

// File: rtl/mbox_fifo_pair.sv
module mbox_fifo_pair
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NCORE-1:0]            push_i,
  input  logic [NCORE-1:0][DATA_W-1:0] push_data_i,
  input  logic [NCORE-1:0]            pop_i,
  output logic [NCORE-1:0][DATA_W-1:0] pop_data_o,
  input  logic [NCORE-1:0]            stat_wr_i,
  input  logic [NCORE-1:0][DATA_W-1:0] stat_wdata_i,
  output logic [NCORE-1:0][DATA_W-1:0] stat_o
);
  logic [NCORE-1:0][DATA_W-1:0] head;
  logic [NCORE-1:0]             full, empty, q_pop;

  // queue c is written by core c and drained by its peer
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    localparam int unsigned PEER = (c == 0) ? 1 : 0;

    assign q_pop[c] = pop_i[PEER];

    mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push_i[c]),
      .push_data_i (push_data_i[c]),
      .pop_i       (q_pop[c]),
      .head_o      (head[c]),
      .full_o      (full[c]),
      .empty_o     (empty[c])
    );

    mbox_core_stat #(.DW(DATA_W)) u_stat (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_i       (push_i[c]),
      .pop_i        (pop_i[c]),
      .tx_full_i    (full[c]),
      .rx_empty_i   (empty[PEER]),
      .rx_head_i    (head[PEER]),
      .stat_wr_i    (stat_wr_i[c]),
      .stat_wdata_i (stat_wdata_i[c]),
      .stat_o       (stat_o[c]),
      .rd_data_o    (pop_data_o[c])
    );
  end
endmodule

// File: rtl/mbox_fifo_pair_chk.sv
module mbox_fifo_pair_chk
  import mbox_pkg::*;
(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NCORE-1:0]            push_i,
  input logic [NCORE-1:0]            pop_i,
  input logic [NCORE-1:0][DATA_W-1:0] pop_data_o,
  input logic [NCORE-1:0]            stat_wr_i,
  input logic [NCORE-1:0][DATA_W-1:0] stat_wdata_i,
  input logic [NCORE-1:0][DATA_W-1:0] stat_o
);
  for (genvar k = 0; k < NCORE; k++) begin : g_k
    localparam int unsigned PEER = (k == 0) ? 1 : 0;

    assert_overflow_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i[k] && !stat_o[k][ST_READY] |=> stat_o[k][ST_OVF]);

    assert_full_push_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i[k] && !stat_o[k][ST_READY] && !pop_i[PEER] |=> !stat_o[k][ST_READY]);

    assert_underflow_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i[k] && !stat_o[k][ST_VALID] |=> stat_o[k][ST_UNF] && (pop_data_o[k] == '0));

    assert_ovf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[k][ST_OVF] && !(stat_wr_i[k] && stat_wdata_i[k][ST_OVF]) |=> stat_o[k][ST_OVF]);

    assert_unf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[k][ST_UNF] && !(stat_wr_i[k] && stat_wdata_i[k][ST_UNF]) |=> stat_o[k][ST_UNF]);

    assert_ovf_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_wr_i[k] && stat_wdata_i[k][ST_OVF] && !(push_i[k] && !stat_o[k][ST_READY])
      |=> !stat_o[k][ST_OVF]);

    assert_valid_after_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i[PEER] && stat_o[PEER][ST_READY] |=> stat_o[k][ST_VALID]);

    assert_reserved_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[k][DATA_W-1:ST_USED_W] == '0);
  end
endmodule

bind mbox_fifo_pair mbox_fifo_pair_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .pop_data_o   (pop_data_o),
  .stat_wr_i    (stat_wr_i),
  .stat_wdata_i (stat_wdata_i),
  .stat_o       (stat_o)
);

// File: tb/mbox_fifo_pair_tb.sv
module mbox_fifo_pair_tb_top;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       push = '0, pop = '0, stwr = '0;
  logic [1:0][31:0] pdata = '0, stwdata = '0;
  logic [1:0][31:0] rdata, stat;
  int               n_chk = 0, n_fail = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;

  mbox_fifo_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(pdata),
    .pop_i(pop), .pop_data_o(rdata), .stat_wr_i(stwr), .stat_wdata_i(stwdata),
    .stat_o(stat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k, input int i);
    return 32'hA500_0000 | (k << 16) | (i * 32'h0111);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; push = '0; pop = '0; stwr = '0;
    repeat (2) @(negedge clk);
    check("R10 stat0 in reset", stat[0], 32'h2);
    check("R10 stat1 in reset", stat[1], 32'h2);
    check("R10 rdata0 in reset", rdata[0], 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 stat1 after reset", stat[1], 32'h2);
    check("R10 rdata1 after reset", rdata[1], 32'h0);
  endtask

  task automatic do_push(input int k, input logic [31:0] d);
    pdata[k] = d; push[k] = 1'b1;
    @(negedge clk);
    push[k] = 1'b0;
  endtask

  task automatic do_pop(input int k, output logic [31:0] d);
    pop[k] = 1'b1;
    @(negedge clk);
    pop[k] = 1'b0;
    d = rdata[k];
  endtask

  task automatic t_fill_overflow(input int k);
    int peer = 1 - k;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      do_push(k, pat(k, i));
      if (i == 6) check("R2 ready after 7 pushes", 32'(stat[k][1]), 32'h1);
    end
    check("R2 R6 ready low when full", 32'(stat[k][1]), 32'h0);
    check("R7 peer valid", 32'(stat[peer][0]), 32'h1);
    do_push(k, 32'hDEAD_BEEF);
    check("R3 overflow flag", 32'(stat[k][2]), 32'h1);
    check("R8 reserved bits", stat[k] >> 4, 32'h0);
    for (int i = 0; i < 8; i++) begin
      do_pop(peer, d);
      check("R1 R3 drained word", d, pat(k, i));
    end
    check("R7 peer valid low when empty", 32'(stat[peer][0]), 32'h0);
    check("R6 ready back", 32'(stat[k][1]), 32'h1);
  endtask

  task automatic t_underflow(input int k);
    int peer = 1 - k;
    logic [31:0] d;
    do_pop(k, d);
    check("R4 empty pop data zero", d, 32'h0);
    check("R4 underflow flag", 32'(stat[k][3]), 32'h1);
    check("R4 valid stays low", 32'(stat[k][0]), 32'h0);
    do_push(peer, 32'h1234_5678);
    do_pop(k, d);
    check("R4 pointer unmoved", d, 32'h1234_5678);
  endtask

  task automatic stat_write(input int k, input logic [31:0] w);
    stwdata[k] = w; stwr[k] = 1'b1;
    @(negedge clk);
    stwr[k] = 1'b0;
  endtask

  task automatic t_clear(input int k);
    stat_write(k, 32'h3);
    check("R5 zero bits keep flags", stat[k] & 32'hC, 32'hC);
    stat_write(k, 32'h4);
    check("R5 clear overflow only", stat[k] & 32'hC, 32'h8);
    stat_write(k, 32'h8);
    check("R5 clear underflow", stat[k] & 32'hC, 32'h0);
    for (int i = 0; i < 8; i++) do_push(k, pat(k, i));
    pdata[k] = 32'hBAD0_0001; push[k] = 1'b1;
    stwdata[k] = 32'h4; stwr[k] = 1'b1;
    @(negedge clk);
    push[k] = 1'b0; stwr[k] = 1'b0;
    check("R5 set beats clear", 32'(stat[k][2]), 32'h1);
  endtask

  task automatic t_simul();
    logic [31:0] d;
    logic [31:0] exp_q[$];
    for (int i = 0; i < 3; i++) begin
      do_push(0, pat(0, i));
      exp_q.push_back(pat(0, i));
    end
    for (int i = 0; i < 4; i++) begin
      pdata[0] = pat(0, 16 + i); push[0] = 1'b1; pop[1] = 1'b1;
      exp_q.push_back(pat(0, 16 + i));
      @(negedge clk);
      check("R9 R1 word during push+pop", rdata[1], exp_q.pop_front());
    end
    push[0] = 1'b0; pop[1] = 1'b0;
    for (int i = 0; i < 5; i++) begin
      do_push(0, pat(0, 32 + i));
      exp_q.push_back(pat(0, 32 + i));
      if (i == 3) check("R9 room kept after push+pop", 32'(stat[0][1]), 32'h1);
    end
    check("R9 full after 5 more", 32'(stat[0][1]), 32'h0);
    for (int i = 0; i < 8; i++) begin
      do_pop(1, d);
      check("R1 R9 order", d, exp_q.pop_front());
    end
  endtask

  initial begin
    do_reset();
    t_fill_overflow(0);
    t_underflow(0);
    t_clear(0);
    do_reset();
    t_fill_overflow(1);
    t_underflow(1);
    t_simul();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule